// File: doc/BRIEF.md
# Cascaded 32-bit Capture Counter

This block joins two 16-bit counters into one 32-bit count. The lower half advances either on an internal count enable or from a pair of external quadrature inputs. The upper half moves only when the lower half wraps. It counts up by one when the lower half passes from all-ones to zero, and down by one when the lower half passes from zero to all-ones. Both halves are registered in the same clock cycle, so any single step gives a consistent 32-bit value.

Each half has its own capture register and capture pin. A rising edge on a pin copies that half's count into its capture register. If both pins rise in the same synchronized cycle, both registers load from the same cycle and together hold a coherent 32-bit snapshot. The quadrature inputs and capture pins are asynchronous. Each one passes through a two-flop synchronizer and then an edge detector. A small register port lets software preset either counter and read all four registers.

Top module: `casc_capture_counter`

## Requirements
- R1: After reset, both counters and both capture registers read zero.
- R2: With `phase_mode`=0, the lower counter increments by one on every clock where `int_tick`=1. With `phase_mode`=1, `int_tick` has no effect.
- R3: With `phase_mode`=1, an input change driven before clock edge k is counted at edge k+2. The count goes up for each of these changes: A rises while B=0, B rises while A=1, A falls while B=1, B falls while A=0. Each opposite change counts down. When A and B change together, nothing is counted.
- R4: When the lower counter steps up from 0xFFFF, it becomes 0x0000 and the upper counter increments by one in the same cycle.
- R5: When the lower counter steps down from 0x0000, it becomes 0xFFFF and the upper counter decrements by one in the same cycle.
- R6: A rising edge on `cap_lo_pin` (or `cap_hi_pin`) driven before edge k loads the lower (or upper) count into `cap_lo` (or `cap_hi`) at edge k+2. The value loaded is the count held between edges k+1 and k+2.
- R7: Rising edges on both capture pins in the same cycle load `{cap_hi,cap_lo}` with the full 32-bit count from one single cycle.
- R8: A write to a counter address takes priority over counting in that cycle. A lower-counter write loads the written value and suppresses any carry or borrow. An upper-counter write loads the upper counter.
- R9: Register addresses are 0 for the lower counter, 1 for the upper counter, 2 for the lower capture and 3 for the upper capture. `reg_rdata` shows the addressed register combinationally. Writes to addresses 2 and 3 are ignored.
- R10: A capture register holds its value in every cycle without a rising edge on its own pin; falling edges do not load it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | Internal count enable for the lower half |
| phase_mode | input | 1 | 1 selects quadrature counting of the lower half |
| ph_a | input | 1 | Quadrature input A (asynchronous) |
| ph_b | input | 1 | Quadrature input B (asynchronous) |
| cap_lo_pin | input | 1 | Lower-half capture pin (asynchronous) |
| cap_hi_pin | input | 1 | Upper-half capture pin (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Addressed register contents |
| cap_lo | output | 16 | Lower capture register |
| cap_hi | output | 16 | Upper capture register |

## Verification
The assertions check the following on every cycle:
- carry and borrow move the upper half in step with the lower half's wrap;
- a lower-counter write lands exactly;
- a dual capture copies one cycle's full count;
- each capture register stays unchanged when its edge is absent;
- the decoder never signals both directions at once.

Other behaviours can only be shown by the bench's scenarios. These are the two-cycle synchronizer latency, the exact quadrature direction table, double-input changes being ignored, the tick being ignored in phase mode, and writes to capture addresses having no effect. The bench's reference model covers them over long random quadrature walks and near-wrap presets.

// File: rtl/casc_pkg.sv
package casc_pkg;

    typedef enum logic [1:0] {
        ADDR_CNT_LO = 2'd0,
        ADDR_CNT_HI = 2'd1,
        ADDR_CAP_LO = 2'd2,
        ADDR_CAP_HI = 2'd3
    } reg_addr_e;

    localparam int IDX_PH_A   = 0;
    localparam int IDX_PH_B   = 1;
    localparam int IDX_CAP_LO = 2;
    localparam int IDX_CAP_HI = 3;
    localparam int N_ASYNC    = 4;

endpackage

// File: rtl/casc_sync_edge.sv
module casc_sync_edge #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/casc_quad_decode.sv
module casc_quad_decode (
    input  logic a_now,
    input  logic a_old,
    input  logic b_now,
    input  logic b_old,
    output logic up_o,
    output logic dn_o
);
    logic a_chg, b_chg;

    always_comb begin
        a_chg = a_now ^ a_old;
        b_chg = b_now ^ b_old;
        up_o  = 1'b0;
        dn_o  = 1'b0;
        if (a_chg && !b_chg) begin
            up_o = a_now ^ b_now;
            dn_o = ~(a_now ^ b_now);
        end else if (b_chg && !a_chg) begin
            up_o = ~(a_now ^ b_now);
            dn_o = a_now ^ b_now;
        end
    end

endmodule

// File: rtl/casc_capture_counter.sv
module casc_capture_counter
    import casc_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_tick,
    input  logic              phase_mode,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              cap_lo_pin,
    input  logic              cap_hi_pin,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi
);
    localparam logic [HALF_W-1:0] ALL_ONES = {HALF_W{1'b1}};
    localparam logic [HALF_W-1:0] ONE      = HALF_W'(1);

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] cap_lo;
        logic [HALF_W-1:0] cap_hi;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic [N_ASYNC-1:0] async_in, sync_lvl, sync_prev;
    logic               quad_up, quad_dn;
    logic               step_up, step_dn;
    logic               wr_lo, wr_hi, carry, borrow;
    logic [1:0]         cap_rise;
    logic [HALF_W-1:0]  lo_now, hi_now;

    assign async_in = {cap_hi_pin, cap_lo_pin, ph_b, ph_a};

    casc_sync_edge #(
        .N      (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_in),
        .lvl_o   (sync_lvl),
        .prev_o  (sync_prev)
    );

    casc_quad_decode i_quad (
        .a_now (sync_lvl[IDX_PH_A]),
        .a_old (sync_prev[IDX_PH_A]),
        .b_now (sync_lvl[IDX_PH_B]),
        .b_old (sync_prev[IDX_PH_B]),
        .up_o  (quad_up),
        .dn_o  (quad_dn)
    );

    always_comb begin
        cap_rise[0] = sync_lvl[IDX_CAP_LO] & ~sync_prev[IDX_CAP_LO];
        cap_rise[1] = sync_lvl[IDX_CAP_HI] & ~sync_prev[IDX_CAP_HI];
    end

    always_comb begin
        st_d    = st_q;
        step_up = phase_mode ? quad_up : int_tick;
        step_dn = phase_mode & quad_dn;
        wr_lo   = reg_wr && (reg_addr == ADDR_CNT_LO);
        wr_hi   = reg_wr && (reg_addr == ADDR_CNT_HI);
        carry   = step_up && (st_q.lo == ALL_ONES) && !wr_lo;
        borrow  = step_dn && (st_q.lo == '0) && !wr_lo;

        if (wr_lo)        st_d.lo = reg_wdata;
        else if (step_up) st_d.lo = st_q.lo + ONE;
        else if (step_dn) st_d.lo = st_q.lo - ONE;

        if (wr_hi)        st_d.hi = reg_wdata;
        else if (carry)   st_d.hi = st_q.hi + ONE;
        else if (borrow)  st_d.hi = st_q.hi - ONE;

        if (cap_rise[0])  st_d.cap_lo = st_q.lo;
        if (cap_rise[1])  st_d.cap_hi = st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CNT_LO: reg_rdata = st_q.lo;
            ADDR_CNT_HI: reg_rdata = st_q.hi;
            ADDR_CAP_LO: reg_rdata = st_q.cap_lo;
            default:     reg_rdata = st_q.cap_hi;
        endcase
    end

    assign lo_now = st_q.lo;
    assign hi_now = st_q.hi;
    assign cap_lo = st_q.cap_lo;
    assign cap_hi = st_q.cap_hi;

endmodule

// File: rtl/casc_capture_checker.sv
module casc_capture_checker #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [HALF_W-1:0] reg_wdata,
    input logic [HALF_W-1:0] lo_q,
    input logic [HALF_W-1:0] hi_q,
    input logic              step_up,
    input logic              step_dn,
    input logic              quad_up,
    input logic              quad_dn,
    input logic [1:0]        cap_rise,
    input logic [HALF_W-1:0] cap_lo,
    input logic [HALF_W-1:0] cap_hi
);
    AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q == {HALF_W{1'b1}} && step_up && !reg_wr)
        |=> (lo_q == '0 && hi_q == HALF_W'($past(hi_q) + 1'b1))); // R4

    AST_BORROW_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q == '0 && step_dn && !step_up && !reg_wr)
        |=> (lo_q == {HALF_W{1'b1}} && hi_q == HALF_W'($past(hi_q) - 1'b1))); // R5

    AST_WR_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (lo_q == $past(reg_wdata))); // R8

    AST_DUAL_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rise == 2'b11) |=> ({cap_hi, cap_lo} == $past({hi_q, lo_q}))); // R7

    AST_CAP_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise[0] |=> $stable(cap_lo)); // R10

    AST_CAP_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise[1] |=> $stable(cap_hi)); // R10

    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(quad_up && quad_dn)); // R3

    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({step_up, step_dn}) <= 1); // R2

endmodule

bind casc_capture_counter casc_capture_checker #(.HALF_W(HALF_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lo_q      (lo_now),
    .hi_q      (hi_now),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .quad_up   (quad_up),
    .quad_dn   (quad_dn),
    .cap_rise  (cap_rise),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi)
);

// File: tb/test_casc_capture_counter.sv
`timescale 1ns/1ps
module test_casc_capture_counter;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         int_tick = 1'b0, phase_mode = 1'b0;
    logic         ph_a = 1'b0, ph_b = 1'b0;
    logic         cap_lo_pin = 1'b0, cap_hi_pin = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata, cap_lo, cap_hi;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    casc_capture_counter i_casc_capture_counter (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .phase_mode(phase_mode),
        .ph_a(ph_a), .ph_b(ph_b), .cap_lo_pin(cap_lo_pin), .cap_hi_pin(cap_hi_pin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    // reference model built from the requirements
    logic [W-1:0] m_lo = '0, m_hi = '0, m_clo = '0, m_chi = '0;
    logic a1 = 0, a2 = 0, a3 = 0, b1 = 0, b2 = 0, b3 = 0;
    logic l1 = 0, l2 = 0, l3 = 0, h1 = 0, h2 = 0, h3 = 0;
    logic [1:0]   md;
    logic         mu, mdn;
    logic [W-1:0] nlo, nhi;

    function automatic logic [1:0] quad_dir(input logic an, ao, bn, bo);
        if ((an != ao) && (bn != bo)) return 2'b00;
        if (an != ao) return (an != bn) ? 2'b10 : 2'b01;
        if (bn != bo) return (an == bn) ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] next_ab(input logic a, b, up);
        logic [1:0] s;
        s = {a, b};
        if (up) case (s) 2'b00: return 2'b10; 2'b10: return 2'b11;
                         2'b11: return 2'b01; default: return 2'b00; endcase
        else    case (s) 2'b00: return 2'b01; 2'b01: return 2'b11;
                         2'b11: return 2'b10; default: return 2'b00; endcase
    endfunction

    function automatic logic [W-1:0] m_read(input logic [1:0] a);
        case (a) 2'd0: return m_lo; 2'd1: return m_hi;
                 2'd2: return m_clo; default: return m_chi; endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo <= '0; m_hi <= '0; m_clo <= '0; m_chi <= '0;
            {a1, a2, a3, b1, b2, b3, l1, l2, l3, h1, h2, h3} <= '0;
        end else begin
            md  = quad_dir(a2, a3, b2, b3);
            mu  = phase_mode ? md[1] : int_tick;
            mdn = phase_mode & md[0];
            nlo = m_lo; nhi = m_hi;
            if (reg_wr && reg_addr == 2'd0) nlo = reg_wdata;
            else if (mu) begin nlo = m_lo + 1'b1; if (m_lo == 16'hFFFF) nhi = m_hi + 1'b1; end
            else if (mdn) begin nlo = m_lo - 1'b1; if (m_lo == 16'h0000) nhi = m_hi - 1'b1; end
            if (reg_wr && reg_addr == 2'd1) nhi = reg_wdata;
            if (l2 && !l3) m_clo <= m_lo;
            if (h2 && !h3) m_chi <= m_hi;
            m_lo <= nlo; m_hi <= nhi;
            a1 <= ph_a; a2 <= a1; a3 <= a2; b1 <= ph_b; b2 <= b1; b3 <= b2;
            l1 <= cap_lo_pin; l2 <= l1; l3 <= l2; h1 <= cap_hi_pin; h2 <= h1; h3 <= h2;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic qmove(input logic up);
        logic [1:0] n;
        n = next_ab(ph_a, ph_b, up);
        ph_a = n[1]; ph_b = n[0];
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] v, hi_keep;
        logic [1:0]   prev_addr;
        logic         run_up;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v); chk("R1 reset value", v, 16'h0000);
        end

        // R4 carry
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'h03A1);
        int_tick = 1'b1; @(negedge clk); int_tick = 1'b0;
        rd(2'd0, v); chk("R4 lower after wrap", v, 16'h0000);
        rd(2'd1, v); chk("R4 upper after carry", v, 16'h03A2);

        // R2 internal tick
        int_tick = 1'b1; idle(3); int_tick = 1'b0;
        rd(2'd0, v); chk("R2 three ticks", v, 16'h0003);

        // R5 borrow via quadrature, R2 tick ignored in phase mode
        wr(2'd0, 16'h0001);
        phase_mode = 1'b1; int_tick = 1'b1;
        qmove(1'b0); qmove(1'b0); qmove(1'b0);
        idle(4);
        int_tick = 1'b0;
        rd(2'd0, v); chk("R5 lower after borrow", v, 16'hFFFE);
        rd(2'd1, v); chk("R5 upper after borrow", v, 16'h03A1);
        chk("R2 tick ignored in phase mode", v, m_hi);

        // R3 up direction and simultaneous change
        repeat (5) qmove(1'b1);
        idle(4);
        rd(2'd0, v); chk("R3 lower after up steps", v, 16'h0003);
        rd(2'd1, v); chk("R3 upper after up steps", v, 16'h03A2);
        ph_a = ~ph_a; ph_b = ~ph_b; idle(5);
        rd(2'd0, v); chk("R3 double change ignored", v, 16'h0003);
        ph_a = 1'b0; ph_b = 1'b0; idle(5);
        phase_mode = 1'b0;
        rd(2'd0, v); hi_keep = m_hi;

        // R8 write priority
        wr(2'd0, 16'hFFFF);
        int_tick = 1'b1; wr(2'd0, 16'h5555); int_tick = 1'b0;
        rd(2'd0, v); chk("R8 lower write beats tick", v, 16'h5555);
        rd(2'd1, v); chk("R8 no carry on write", v, hi_keep);

        // R9 writes to capture addresses ignored
        wr(2'd2, 16'hBEEF); wr(2'd3, 16'hCAFE);
        rd(2'd2, v); chk("R9 capture lo unwritable", v, 16'h0000);
        rd(2'd3, v); chk("R9 capture hi unwritable", v, 16'h0000);

        // R6 single-pin capture
        cap_lo_pin = 1'b1; idle(4);
        chk("R6 cap_lo loaded", cap_lo, 16'h5555);
        chk("R6 cap_hi untouched", cap_hi, 16'h0000);

        // R10 falling edge does not capture
        wr(2'd0, 16'h0F0F);
        cap_lo_pin = 1'b0; idle(4);
        chk("R10 cap_lo held", cap_lo, 16'h5555);

        // R7 coherent dual capture, frozen and running
        wr(2'd1, 16'h1234);
        cap_lo_pin = 1'b1; cap_hi_pin = 1'b1; idle(4);
        chk("R7 frozen hi", cap_hi, 16'h1234);
        chk("R7 frozen lo", cap_lo, 16'h0F0F);
        cap_lo_pin = 1'b0; cap_hi_pin = 1'b0;
        wr(2'd0, 16'hFFFD); int_tick = 1'b1; idle(1);
        cap_lo_pin = 1'b1; cap_hi_pin = 1'b1; idle(5); int_tick = 1'b0;
        chk("R7 running hi", cap_hi, m_chi);
        chk("R7 running lo", cap_lo, m_clo);
        cap_lo_pin = 1'b0; cap_hi_pin = 1'b0; idle(3);

        // random phase
        void'($urandom(32'h5EED_1234));
        run_up = 1'b1;
        prev_addr = reg_addr;
        for (int c = 0; c < 4000; c++) begin
            chk(phase_mode ? "R3 random read" : "R2 random read", reg_rdata, m_read(prev_addr));
            chk("R6 random cap_lo", cap_lo, m_clo);
            chk("R7 random cap_hi", cap_hi, m_chi);
            if (c % 500 == 0) phase_mode = ~phase_mode;
            if ($urandom_range(15) == 0) run_up = ~run_up;
            int_tick = 1'($urandom_range(1));
            case ($urandom_range(7))
                0, 1, 2: begin
                    logic [1:0] n;
                    n = next_ab(ph_a, ph_b, run_up);
                    ph_a = n[1]; ph_b = n[0];
                end
                3: begin ph_a = ~ph_a; ph_b = ~ph_b; end
                default: ;
            endcase
            if ($urandom_range(11) == 0) cap_lo_pin = ~cap_lo_pin;
            if ($urandom_range(11) == 0) cap_hi_pin = ~cap_hi_pin;
            if ($urandom_range(11) == 0) { cap_lo_pin, cap_hi_pin } = {2{~cap_lo_pin}};
            reg_wr = ($urandom_range(31) == 0);
            reg_addr = 2'($urandom_range(3));
            case ($urandom_range(4))
                0: reg_wdata = 16'hFFFF; 1: reg_wdata = 16'h0000;
                2: reg_wdata = 16'hFFFE; 3: reg_wdata = 16'h0001;
                default: reg_wdata = 16'($urandom);
            endcase
            prev_addr = reg_addr;
            @(negedge clk);
        end
        reg_wr = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule